// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block derives the serial clock of an I2C master from the functional clock. A programmable prescaler turns the functional clock into a sampling tick, and a phase timer counts the low and the high half of each SCL period in those ticks. The low and high lengths come from 16-bit count words, and a fixed trim is added in hardware. Standard mode uses equal low and high counts. Fast mode typically gives about a third of the period to high and two thirds to low. In high-speed mode each count word holds two bytes. The lower byte times the master-code phase and the upper byte times the high-speed phase.

The byte engine raises `run_i` when it needs clock pulses, and `hs_phase_i` once the master code has gone out. It uses the two one-cycle strobes to place SDA: one strobe in the middle of each high phase for sampling, and one in the middle of each low phase for changing data. The SCL output is open-drain style: `scl_low_o` high means pull the line down, and low means release it. Configuration inputs are captured only while the block is disabled and stay frozen while it is enabled.

Top module: `scl_clock_gen`

## Requirements
- R1: With prescale value P > 0, `tick_o` is a one-cycle pulse that repeats every P+1 functional clock cycles.
- R2: Each SCL low phase lasts (L + LO_TRIM) x (P+1) cycles, where L is the selected 8-bit low count and LO_TRIM defaults to 7.
- R3: Each SCL high phase lasts (H + HI_TRIM) x (P+1) cycles, where H is the selected 8-bit high count and HI_TRIM defaults to 5.
- R4: When high-speed mode is captured as 1 and `hs_phase_i` is 1, bits 15:8 of the count words are used; otherwise bits 7:0 are used. With high-speed mode 0, `hs_phase_i` has no effect.
- R5: Prescale, counts and high-speed mode are captured only while `enable_i` is 0. Changes made while enabled have no effect until enable is cleared and set again.
- R6: One cycle after `enable_i` is 0, `scl_low_o` and `tick_o` are 0.
- R7: A clock train starts with a low phase. After `run_i` falls, the current period completes and SCL then stays released.
- R8: Each low phase carries exactly one `change_stb_o` pulse while SCL is low. Each high phase carries exactly one `sample_stb_o` pulse while SCL is released. The two strobes never coincide.
- R9: After reset, all outputs are 0.
- R10: The full 8-bit count range works, up to 255, giving phases of 262 and 260 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Controller enable; 0 captures configuration |
| run_i | input | 1 | Byte engine requests clock pulses |
| hs_phase_i | input | 1 | Use the high-speed byte of the count words |
| cfg_prescale_i | input | PSC_W | Prescale value P |
| cfg_low_i | input | 2*CNT_W | Packed low counts (phase 2 upper, phase 1 lower) |
| cfg_high_i | input | 2*CNT_W | Packed high counts (phase 2 upper, phase 1 lower) |
| cfg_hs_mode_i | input | 1 | High-speed mode select |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| tick_o | output | 1 | Registered sampling tick |
| sample_stb_o | output | 1 | Mid-high SDA sample strobe |
| change_stb_o | output | 1 | Mid-low SDA change strobe |

## Verification
A wrong prescaler count shows up in the very next tick gap and stretches every phase by the same factor. A wrong phase length or byte selection appears in the first SCL period after enable, as a low or high time off by a whole number of ticks. A phase timer stuck in the wrong state shows as a missing or doubled strobe within one phase, or as SCL toggling with no tick beside it. A shadow register that leaks while enabled changes the very next measured phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_shadow.sv
// Holds the timing configuration; follows the inputs only while disabled.
module scl_cfg_shadow #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic [PSC_W-1:0]   psc_i,
  input  logic [2*CNT_W-1:0] lo_i,
  input  logic [2*CNT_W-1:0] hi_i,
  input  logic               hs_i,
  output logic [PSC_W-1:0]   psc_q,
  output logic [2*CNT_W-1:0] lo_q,
  output logic [2*CNT_W-1:0] hi_q,
  output logic               hs_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      hs_q  <= 1'b0;
    end else if (!enable_i) begin
      psc_q <= psc_i;
      lo_q  <= lo_i;
      hi_q  <= hi_i;
      hs_q  <= hs_i;
    end
  end
endmodule

// File: rtl/scl_prescaler.sv
// Divides the functional clock into a sampling tick of period limit+1.
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic [PSC_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;

  assign tick_o = enable_i && (cnt_q == limit_i);

  always_ff @(posedge clk) begin
    if (rst || !enable_i)      cnt_q <= '0;
    else if (cnt_q == limit_i) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_phase_timer.sv
// Times SCL low/high phases in ticks and places the mid-phase strobes.
module scl_phase_timer
  import scl_gen_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LO_TRIM = 7,
  parameter int HI_TRIM = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  output logic             scl_low_o,
  output logic             sample_stb_o,
  output logic             change_stb_o
);
  localparam int LW = CNT_W + 1;

  scl_phase_e    state_q, state_n;
  logic [LW-1:0] cnt_q, cnt_n, len_q, len_n;
  logic [LW-1:0] lo_len, hi_len, last, half;
  logic          samp_n, chg_n;

  assign lo_len = {1'b0, lo_cnt_i} + LW'(LO_TRIM);
  assign hi_len = {1'b0, hi_cnt_i} + LW'(HI_TRIM);
  assign last   = len_q - LW'(1);
  assign half   = len_q >> 1;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    samp_n  = 1'b0;
    chg_n   = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        PH_IDLE: begin
          if (run_i) begin
            state_n = PH_LOW;
            cnt_n   = '0;
            len_n   = lo_len;
          end
        end
        PH_LOW: begin
          chg_n = (cnt_q == half);
          if (cnt_q == last) begin
            state_n = PH_HIGH;
            cnt_n   = '0;
            len_n   = hi_len;
          end else begin
            cnt_n = cnt_q + LW'(1);
          end
        end
        PH_HIGH: begin
          samp_n = (cnt_q == half);
          if (cnt_q == last) begin
            cnt_n = '0;
            if (run_i) begin
              state_n = PH_LOW;
              len_n   = lo_len;
            end else begin
              state_n = PH_IDLE;
            end
          end else begin
            cnt_n = cnt_q + LW'(1);
          end
        end
        default: state_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      state_q      <= PH_IDLE;
      cnt_q        <= '0;
      len_q        <= '0;
      scl_low_o    <= 1'b0;
      sample_stb_o <= 1'b0;
      change_stb_o <= 1'b0;
    end else begin
      state_q      <= state_n;
      cnt_q        <= cnt_n;
      len_q        <= len_n;
      scl_low_o    <= (state_n == PH_LOW);
      sample_stb_o <= samp_n;
      change_stb_o <= chg_n;
    end
  end
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int PSC_W   = 8,
  parameter int CNT_W   = 8,
  parameter int LO_TRIM = 7,
  parameter int HI_TRIM = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic               run_i,
  input  logic               hs_phase_i,
  input  logic [PSC_W-1:0]   cfg_prescale_i,
  input  logic [2*CNT_W-1:0] cfg_low_i,
  input  logic [2*CNT_W-1:0] cfg_high_i,
  input  logic               cfg_hs_mode_i,
  output logic               scl_low_o,
  output logic               tick_o,
  output logic               sample_stb_o,
  output logic               change_stb_o
);
  logic [PSC_W-1:0]   psc_q;
  logic [2*CNT_W-1:0] lo_q, hi_q;
  logic               hs_q, tick, use_hs;
  logic [CNT_W-1:0]   lo_sel, hi_sel;

  scl_cfg_shadow #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .enable_i(enable_i),
    .psc_i(cfg_prescale_i), .lo_i(cfg_low_i), .hi_i(cfg_high_i), .hs_i(cfg_hs_mode_i),
    .psc_q(psc_q), .lo_q(lo_q), .hi_q(hi_q), .hs_q(hs_q)
  );

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .enable_i(enable_i), .limit_i(psc_q), .tick_o(tick)
  );

  // Second-phase byte only when high-speed mode is latched and engine asks.
  assign use_hs = hs_q && hs_phase_i;
  assign lo_sel = use_hs ? lo_q[2*CNT_W-1:CNT_W] : lo_q[CNT_W-1:0];
  assign hi_sel = use_hs ? hi_q[2*CNT_W-1:CNT_W] : hi_q[CNT_W-1:0];

  scl_phase_timer #(.CNT_W(CNT_W), .LO_TRIM(LO_TRIM), .HI_TRIM(HI_TRIM)) u_timer (
    .clk(clk), .rst(rst), .enable_i(enable_i), .tick_i(tick), .run_i(run_i),
    .lo_cnt_i(lo_sel), .hi_cnt_i(hi_sel),
    .scl_low_o(scl_low_o), .sample_stb_o(sample_stb_o), .change_stb_o(change_stb_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !enable_i) tick_o <= 1'b0;
    else                  tick_o <= tick;
  end
endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable_i,
  input logic scl_low_o,
  input logic tick_o,
  input logic sample_stb_o,
  input logic change_stb_o
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb_o && change_stb_o)); // R8
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    sample_stb_o |-> !scl_low_o); // R8
  AST_CHANGE_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    change_stb_o |-> scl_low_o); // R8
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!scl_low_o && !tick_o)); // R6
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (enable_i && $past(enable_i) && !$stable(scl_low_o)) |-> tick_o); // R2
endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
  .clk(clk), .rst(rst), .enable_i(enable_i), .scl_low_o(scl_low_o),
  .tick_o(tick_o), .sample_stb_o(sample_stb_o), .change_stb_o(change_stb_o)
);

// File: tb/scl_clock_gen_bench.sv
`timescale 1ns/1ps
module scl_clock_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable_i = 1'b0, run_i = 1'b0, hs_phase_i = 1'b0, cfg_hs_mode_i = 1'b0;
  logic [7:0]  cfg_prescale_i = '0;
  logic [15:0] cfg_low_i = '0, cfg_high_i = '0;
  logic        scl_low_o, tick_o, sample_stb_o, change_stb_o;

  int total = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_clock_gen u_scl_clock_gen (
    .clk(clk), .rst(rst), .enable_i(enable_i), .run_i(run_i), .hs_phase_i(hs_phase_i),
    .cfg_prescale_i(cfg_prescale_i), .cfg_low_i(cfg_low_i), .cfg_high_i(cfg_high_i),
    .cfg_hs_mode_i(cfg_hs_mode_i), .scl_low_o(scl_low_o), .tick_o(tick_o),
    .sample_stb_o(sample_stb_o), .change_stb_o(change_stb_o)
  );

  localparam int NV = 7;
  localparam int V_PSC [NV] = '{0, 1, 2, 2, 0, 3, 0};
  localparam int V_LO  [NV] = '{'h0003, 'h0008, 'h0401, 'h0401, 'h0401, 'h0000, 'h00FF};
  localparam int V_HI  [NV] = '{'h0003, 'h0002, 'h0300, 'h0300, 'h0300, 'h0000, 'h00FF};
  localparam int V_HS  [NV] = '{0, 0, 1, 1, 0, 0, 0};
  localparam int V_PH  [NV] = '{0, 0, 0, 1, 1, 0, 0};
  localparam int E_LO  [NV] = '{10, 30, 24, 33, 8, 28, 262};
  localparam int E_HI  [NV] = '{8, 14, 15, 24, 5, 20, 260};

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(int psc, int lo, int hi, int hs, int ph);
    @(negedge clk);
    enable_i = 1'b0; run_i = 1'b0;
    cfg_prescale_i = 8'(psc); cfg_low_i = 16'(lo); cfg_high_i = 16'(hi);
    cfg_hs_mode_i = 1'(hs); hs_phase_i = 1'(ph);
    repeat (2) @(negedge clk);
    enable_i = 1'b1; run_i = 1'b1;
  endtask

  // Skips any partial low, then measures one full low and the following high.
  task automatic measure(output int lo_c, output int hi_c, output int chg, output int smp);
    lo_c = 0; hi_c = 0; chg = 0; smp = 0;
    while (scl_low_o) @(negedge clk);
    while (!scl_low_o) @(negedge clk);
    while (scl_low_o) begin
      lo_c++; chg += int'(change_stb_o);
      @(negedge clk);
    end
    while (!scl_low_o) begin
      hi_c++; smp += int'(sample_stb_o);
      @(negedge clk);
    end
  endtask

  initial begin
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int lo_c, hi_c, chg, smp, n;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 scl", int'(scl_low_o), 0);
    chk("R9 tick", int'(tick_o), 0);
    chk("R9 strobes", int'(sample_stb_o | change_stb_o), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      configure(V_PSC[i], V_LO[i], V_HI[i], V_HS[i], V_PH[i]);
      measure(lo_c, hi_c, chg, smp);
      chk($sformatf("R2/R4/R10 low v%0d", i), lo_c, E_LO[i]);
      chk($sformatf("R3/R4/R10 high v%0d", i), hi_c, E_HI[i]);
      chk($sformatf("R8 change v%0d", i), chg, 1);
      chk($sformatf("R8 sample v%0d", i), smp, 1);
    end

    // R1: tick period and width with P=2
    configure(2, 3, 3, 0, 0);
    while (!tick_o) @(negedge clk);
    @(negedge clk);
    chk("R1 width", int'(tick_o), 0);
    n = 1;
    while (!tick_o) begin @(negedge clk); n++; end
    chk("R1 period", n, 3);

    // R5: writes while enabled are ignored until re-enable
    configure(0, 'h0003, 'h0003, 0, 0);
    cfg_prescale_i = 8'd1; cfg_low_i = 16'h0020; cfg_high_i = 16'h0010;
    measure(lo_c, hi_c, chg, smp);
    chk("R5 frozen low", lo_c, 10);
    chk("R5 frozen high", hi_c, 8);
    configure(1, 'h0020, 'h0010, 0, 0);
    measure(lo_c, hi_c, chg, smp);
    chk("R5 new low", lo_c, 78);
    chk("R5 new high", hi_c, 42);

    // R7: run drops, period completes, then SCL stays released
    configure(0, 'h0003, 'h0003, 0, 0);
    measure(lo_c, hi_c, chg, smp);
    run_i = 1'b0;
    n = 0;
    while (scl_low_o) begin @(negedge clk); n++; end
    chk("R7 last low completes", n, 10);
    n = 0; smp = 0;
    for (int k = 0; k < 100; k++) begin
      n += int'(scl_low_o); smp += int'(sample_stb_o);
      @(negedge clk);
    end
    chk("R7 released", n, 0);
    chk("R7 one final sample", smp, 1);

    // R6: disable releases SCL and stops the tick
    run_i = 1'b1;
    while (!scl_low_o) @(negedge clk);
    enable_i = 1'b0;
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      n += int'(scl_low_o) + int'(tick_o);
      @(negedge clk);
    end
    chk("R6 idle when disabled", n, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule